// File: doc/BRIEF.md
# Serial Flash Host Controller

This block drives a serial NOR flash over a four-wire SPI link in clock mode 0. A host presents a request with a single valid strobe. A read request gives a 24-bit start address and a byte count. A write request gives a 24-bit address and one data byte. Reads go out as one uninterrupted burst under a single chip-select frame. Each returned byte appears on `rd_data` together with a one-cycle `rd_valid` strobe, in address order.

A write runs as a chain of frames with no further host action. The chain is a write-enable frame, then the program frame, which launches the flash's self-timed write when chip select rises. Status-read frames then repeat until the busy bit reads clear. Only then does `wr_done` pulse. While any of this is in progress, `req_ready` is low and the controller ignores new requests. Between two frames, chip select stays high for a configurable minimum number of system clocks. SCK is derived from the system clock by a parameterized divider.

Top module: `spi_flash_ctrl`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, `req_ready` is 1, and `rd_valid` and `wr_done` are 0.
- R2: SCK idles low, and each SCK phase lasts SCK_DIV system clocks. MOSI changes only while SCK is low. MISO is captured when SCK rises. A frame of N bytes carries exactly 8*N SCK rising edges.
- R3: A read of LEN bytes at address A is one chip-select frame. The frame carries opcode 0x03, then A[23:16], A[15:8] and A[7:0], MSB first, then LEN data bytes. Each data byte is presented on `rd_data` with a one-cycle `rd_valid`, and chip select rises after the last one.
- R4: Every write request is preceded by its own write-enable frame, which holds only opcode 0x06.
- R5: The program frame carries opcode 0x02, the three address bytes (high byte first) and the data byte. Chip select rises immediately after the data byte.
- R6: After the program frame, status frames are sent repeatedly. Each holds opcode 0x05 plus one read byte, whose bit 0 set to 1 means busy. Polling continues for as long as that bit reads 1.
- R7: `wr_done` is a single-cycle pulse. It is raised only after a status byte has returned bit 0 equal to 0.
- R8: Between any two frames, chip select stays high for at least CS_GAP system clocks.
- R9: A request is accepted only while `req_ready` is 1. A request presented while an operation is in progress is ignored and produces no frame and no strobe.
- R10: A read request with a byte count of 0 is ignored. No frame starts and `req_ready` stays 1.
- R11: `req_ready` is 0 whenever chip select is low, and `rd_valid` and `wr_done` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = single-byte program, 0 = read burst |
| req_addr | input | 24 | Flash byte address |
| req_len | input | LEN_W | Read byte count |
| req_wdata | input | 8 | Byte to program |
| req_ready | output | 1 | Controller idle and able to accept |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| wr_done | output | 1 | One-cycle pulse when a program has completed |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The bench builds the controller with SCK_DIV = 2, CS_GAP = 3 and LEN_W = 16. With SCK_DIV = 2, a flash model that updates MISO one system clock after SCK falls still meets the controller's sampling point, and the bench can count SCK edges per frame exactly. The model holds its busy bit for 400 system clocks after each program. That is long enough to force several status frames, so the poll loop and the guarded `wr_done` are exercised. With CS_GAP = 3, the high-time measurement between chained frames catches a gap that is one or two clocks short.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    localparam int ADDR_W = 24;

    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_PROG = 8'h02;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_STAT = 8'h05;

    // position of the data-phase byte in read and program frames
    localparam logic [2:0] DATA_IDX = 3'd4;

    typedef enum logic [1:0] {
        FR_READ,
        FR_WREN,
        FR_PROG,
        FR_STAT
    } frame_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GAP,
        ST_XFER
    } seq_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [7:0]        wdata;
    } op_args_t;

    function automatic logic [7:0] frame_opcode(frame_e k);
        case (k)
            FR_READ: return OP_READ;
            FR_WREN: return OP_WREN;
            FR_PROG: return OP_PROG;
            default: return OP_STAT;
        endcase
    endfunction

    // index of the final fixed-position byte of each frame kind
    function automatic logic [2:0] frame_last_idx(frame_e k);
        case (k)
            FR_WREN: return 3'd0;
            FR_STAT: return 3'd1;
            default: return DATA_IDX;
        endcase
    endfunction

    // byte shifted out at a given position of a frame
    function automatic logic [7:0] frame_byte(frame_e k, logic [2:0] idx, op_args_t a);
        if (idx == 3'd0)
            return frame_opcode(k);
        if (k == FR_STAT || k == FR_WREN)
            return 8'h00;
        case (idx)
            3'd1:    return a.addr[23:16];
            3'd2:    return a.addr[15:8];
            3'd3:    return a.addr[7:0];
            default: return (k == FR_PROG) ? a.wdata : 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/sfc_tick.sv
module sfc_tick #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = en && (cnt == LAST);
endmodule

// File: rtl/sfc_byte_io.sv
module sfc_byte_io (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       go,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx
);
    logic [7:0] sh;
    logic [2:0] bitn;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck  <= 1'b0;
            mosi <= 1'b0;
            busy <= 1'b0;
            done <= 1'b0;
            sh   <= '0;
            rx   <= '0;
            bitn <= '0;
        end else begin
            done <= 1'b0;
            if (go && !busy) begin
                sh   <= tx;
                mosi <= tx[7];
                busy <= 1'b1;
                bitn <= '0;
                sck  <= 1'b0;
            end else if (busy && tick) begin
                if (!sck) begin
                    // rising edge: flash drove MISO on the preceding fall
                    sck <= 1'b1;
                    rx  <= {rx[6:0], miso};
                end else begin
                    sck <= 1'b0;
                    if (bitn == 3'd7) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bitn <= bitn + 1'b1;
                        sh   <= {sh[6:0], 1'b0};
                        mosi <= sh[6];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sfc_seq.sv
module sfc_seq
    import sfc_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int CS_GAP = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [7:0]        req_wdata,
    input  logic              io_done,
    input  logic [7:0]        io_rx,
    output logic              req_ready,
    output logic              io_go,
    output logic [7:0]        io_tx,
    output logic              cs_n,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              wr_done
);
    localparam int GAP_MAX = CS_GAP + 1;
    localparam int GW      = $clog2(GAP_MAX + 1);

    seq_state_e       state;
    frame_e           kind;
    op_args_t         args;
    logic [2:0]       idx;
    logic [LEN_W-1:0] rem;
    logic [GW-1:0]    gap_cnt;

    logic accept;
    logic last_byte;
    logic [2:0] idx_nxt;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_ready && req_valid && (req_write || req_len != '0);
    assign last_byte = (idx == frame_last_idx(kind)) &&
                       (kind != FR_READ || rem == LEN_W'(1));
    assign idx_nxt   = (idx == DATA_IDX) ? DATA_IDX : idx + 3'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            kind     <= FR_READ;
            args     <= '0;
            idx      <= '0;
            rem      <= '0;
            gap_cnt  <= GW'(GAP_MAX);
            cs_n     <= 1'b1;
            io_go    <= 1'b0;
            io_tx    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            wr_done  <= 1'b0;
        end else begin
            io_go    <= 1'b0;
            rd_valid <= 1'b0;
            wr_done  <= 1'b0;

            if (!cs_n)
                gap_cnt <= '0;
            else if (gap_cnt != GW'(GAP_MAX))
                gap_cnt <= gap_cnt + 1'b1;

            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        kind       <= req_write ? FR_WREN : FR_READ;
                        args.addr  <= req_addr;
                        args.wdata <= req_wdata;
                        rem        <= req_len;
                        state      <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (gap_cnt >= GW'(CS_GAP)) begin
                        cs_n  <= 1'b0;
                        io_go <= 1'b1;
                        io_tx <= frame_byte(kind, 3'd0, args);
                        idx   <= '0;
                        state <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (io_done) begin
                        if (kind == FR_READ && idx == DATA_IDX) begin
                            rd_valid <= 1'b1;
                            rd_data  <= io_rx;
                            rem      <= rem - 1'b1;
                        end
                        if (last_byte) begin
                            cs_n <= 1'b1;
                            case (kind)
                                FR_READ: state <= ST_IDLE;
                                FR_WREN: begin
                                    kind  <= FR_PROG;
                                    state <= ST_GAP;
                                end
                                FR_PROG: begin
                                    kind  <= FR_STAT;
                                    state <= ST_GAP;
                                end
                                default: begin
                                    if (io_rx[0]) begin
                                        state <= ST_GAP;
                                    end else begin
                                        wr_done <= 1'b1;
                                        state   <= ST_IDLE;
                                    end
                                end
                            endcase
                        end else begin
                            idx   <= idx_nxt;
                            io_go <= 1'b1;
                            io_tx <= frame_byte(kind, idx_nxt, args);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_flash_ctrl.sv
module spi_flash_ctrl
    import sfc_pkg::*;
#(
    parameter int SCK_DIV = 2,
    parameter int CS_GAP  = 3,
    parameter int LEN_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [7:0]        req_wdata,
    output logic              req_ready,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              wr_done,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    logic       io_go;
    logic [7:0] io_tx;
    logic       io_busy;
    logic       io_done;
    logic [7:0] io_rx;
    logic       io_tick;

    sfc_tick #(.DIV(SCK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (io_busy),
        .tick (io_tick)
    );

    sfc_byte_io u_io (
        .clk  (clk),
        .rst  (rst),
        .tick (io_tick),
        .go   (io_go),
        .tx   (io_tx),
        .miso (spi_miso),
        .sck  (spi_sck),
        .mosi (spi_mosi),
        .busy (io_busy),
        .done (io_done),
        .rx   (io_rx)
    );

    sfc_seq #(.LEN_W(LEN_W), .CS_GAP(CS_GAP)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .req_wdata (req_wdata),
        .io_done   (io_done),
        .io_rx     (io_rx),
        .req_ready (req_ready),
        .io_go     (io_go),
        .io_tx     (io_tx),
        .cs_n      (spi_cs_n),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .wr_done   (wr_done)
    );
endmodule

// File: rtl/sfc_chk.sv
module sfc_chk #(
    parameter int CS_GAP = 3
) (
    input logic clk,
    input logic rst,
    input logic req_ready,
    input logic rd_valid,
    input logic wr_done,
    input logic spi_sck,
    input logic spi_cs_n,
    input logic spi_mosi
);
    localparam int HI_MAX = CS_GAP + 2;
    localparam int HW     = $clog2(HI_MAX + 1);

    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            hi_cnt <= HW'(HI_MAX);
        else if (!spi_cs_n)
            hi_cnt <= '0;
        else if (hi_cnt != HW'(HI_MAX))
            hi_cnt <= hi_cnt + 1'b1;
    end

    // R2
    sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);

    // R2
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        spi_sck |-> $stable(spi_mosi));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_done |=> !wr_done);

    // R8
    cs_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs_n) |-> (hi_cnt > HW'(CS_GAP)));

    // R11
    ready_frame_chk: assert property (@(posedge clk) disable iff (rst)
        !spi_cs_n |-> !req_ready);

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_valid && wr_done));
endmodule

bind spi_flash_ctrl sfc_chk #(.CS_GAP(CS_GAP)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .wr_done   (wr_done),
    .spi_sck   (spi_sck),
    .spi_cs_n  (spi_cs_n),
    .spi_mosi  (spi_mosi)
);

// File: tb/test_spi_flash_ctrl.sv
module test_spi_flash_ctrl;
    localparam int SCK_DIV  = 2;
    localparam int CS_GAP   = 3;
    localparam int LEN_W    = 16;
    localparam int BUSY_CYC = 400;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic [23:0]      req_addr  = '0;
    logic [LEN_W-1:0] req_len   = '0;
    logic [7:0]       req_wdata = '0;
    logic             req_ready;
    logic [7:0]       rd_data;
    logic             rd_valid;
    logic             wr_done;
    logic             spi_sck;
    logic             spi_cs_n;
    logic             spi_mosi;
    logic             spi_miso;

    always #5 clk = ~clk;

    spi_flash_ctrl #(.SCK_DIV(SCK_DIV), .CS_GAP(CS_GAP), .LEN_W(LEN_W)) i_spi_flash_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .req_ready(req_ready), .rd_data(rd_data), .rd_valid(rd_valid),
        .wr_done(wr_done), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    task automatic check(input string tag, input bit ok, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- flash model and monitors ----------------
    logic [7:0] mem [256];
    logic       sck_q, cs_q;
    logic [7:0] in_sh, out_sh, op, pdata;
    logic [23:0] addr_acc;
    logic [7:0] rd_ptr;
    int  bitc, bytec, ocnt, busy_cnt;
    bit  wel, out_on;
    int  frames, wren_frames, prog_frames, stat_frames, no_wel_err;
    int  sck_rises, rcount, wdone_cnt, done_early, excl_viol, ready_viol;
    int  hi_run, min_hi;
    logic [23:0] last_addr;
    logic [7:0] rbuf [64];
    logic miso_r;
    assign spi_miso = miso_r;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++)
                mem[i] = (i >= 8'h40 && i < 8'h50) ? 8'hFF : 8'(i * 7 + 3);
            sck_q = 0; cs_q = 1; in_sh = 0; out_sh = 0; op = 0; pdata = 0;
            addr_acc = 0; rd_ptr = 0; bitc = 0; bytec = 0; ocnt = 0; busy_cnt = 0;
            wel = 0; out_on = 0; frames = 0; wren_frames = 0; prog_frames = 0;
            stat_frames = 0; no_wel_err = 0; sck_rises = 0; rcount = 0; wdone_cnt = 0;
            done_early = 0; excl_viol = 0; ready_viol = 0; hi_run = 100; min_hi = 100;
            last_addr = 0;
            miso_r <= 1'b0;
        end else begin
            if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
            if (rd_valid) begin
                if (rcount < 64) rbuf[rcount] = rd_data;
                rcount++;
            end
            if (wr_done) begin
                wdone_cnt++;
                if (busy_cnt != 0) done_early++;
            end
            if (rd_valid && wr_done) excl_viol++;
            if (!spi_cs_n && req_ready) ready_viol++;
            if (spi_cs_n) hi_run++;
            // chip select fall
            if (cs_q && !spi_cs_n) begin
                if (frames > 0 && hi_run < min_hi) min_hi = hi_run;
                frames++;
                bitc = 0; bytec = 0; ocnt = 0; out_on = 0; op = 8'h00;
            end
            // chip select rise
            if (!cs_q && spi_cs_n) begin
                hi_run = 0;
                if (op == 8'h06 && bytec == 1) begin
                    wel = 1; wren_frames++;
                end else if (op == 8'h02 && bytec == 5) begin
                    prog_frames++;
                    if (wel) begin
                        mem[addr_acc[7:0]] = mem[addr_acc[7:0]] & pdata;
                        busy_cnt = BUSY_CYC;
                        last_addr = addr_acc;
                    end else no_wel_err++;
                    wel = 0;
                end else if (op == 8'h05) stat_frames++;
                else if (op == 8'h03) last_addr = addr_acc;
                out_on = 0;
            end
            if (!spi_cs_n && !sck_q && spi_sck) begin
                sck_rises++;
                in_sh = {in_sh[6:0], spi_mosi};
                bitc++;
                if (bitc == 8) begin
                    bitc = 0;
                    if (bytec == 0) begin
                        op = in_sh;
                        if (in_sh == 8'h05) begin
                            out_sh = {7'b0, busy_cnt != 0}; out_on = 1; ocnt = 0;
                        end
                    end else if (bytec <= 3) begin
                        addr_acc = {addr_acc[15:0], in_sh};
                        if (bytec == 3 && op == 8'h03) begin
                            rd_ptr = addr_acc[7:0];
                            out_sh = mem[rd_ptr]; out_on = 1; ocnt = 0;
                        end
                    end else if (bytec == 4 && op == 8'h02) pdata = in_sh;
                    bytec++;
                end
            end
            if (!spi_cs_n && sck_q && !spi_sck && out_on) begin
                miso_r <= out_sh[7];
                out_sh = {out_sh[6:0], 1'b0};
                ocnt++;
                if (ocnt == 8) begin
                    ocnt = 0;
                    if (op == 8'h03) begin
                        rd_ptr = rd_ptr + 8'd1;
                        out_sh = mem[rd_ptr];
                    end else out_sh = {7'b0, busy_cnt != 0};
                end
            end
            sck_q = spi_sck;
            cs_q  = spi_cs_n;
        end
    end

    // ---------------- scenario tasks ----------------
    task automatic wait_idle();
        int t = 0;
        @(negedge clk);
        while (!req_ready && t < 20000) begin
            @(negedge clk); t++;
        end
    endtask

    task automatic issue(input bit w, input logic [23:0] a, input int len, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1; req_write = w; req_addr = a; req_len = LEN_W'(len); req_wdata = d;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic test_reset();
        check("R1 cs_n high", spi_cs_n == 1, spi_cs_n, 1);
        check("R1 sck low", spi_sck == 0, spi_sck, 0);
        check("R1 ready", req_ready == 1, req_ready, 1);
        check("R1 strobes", (rd_valid | wr_done) == 0, rd_valid | wr_done, 0);
    endtask

    task automatic test_read(input logic [23:0] a, input int len);
        int r0 = rcount, f0 = frames, s0 = sck_rises;
        issue(0, a, len, 8'h00);
        wait_idle();
        repeat (4) @(negedge clk);
        check("R3 byte count", rcount - r0 == len, rcount - r0, len);
        check("R3 single frame", frames - f0 == 1, frames - f0, 1);
        check("R3 address seen", last_addr == a, int'(last_addr), int'(a));
        check("R2 sck rises", sck_rises - s0 == 8 * (4 + len), sck_rises - s0, 8 * (4 + len));
        check("R3 cs released", spi_cs_n == 1, spi_cs_n, 1);
        for (int i = 0; i < len; i++) begin
            logic [7:0] e = mem[8'(a[7:0] + i)];
            check("R3 read data", rbuf[r0 + i] == e, rbuf[r0 + i], e);
        end
    endtask

    task automatic test_prog(input logic [23:0] a, input logic [7:0] d, input logic [7:0] exp);
        int f_w = wren_frames, f_p = prog_frames, f_s = stat_frames;
        int r0 = rcount, d0 = wdone_cnt, n0 = no_wel_err, fr0;
        issue(1, a, 0, d);
        repeat (40) @(negedge clk);
        check("R9 busy not ready", req_ready == 0, req_ready, 0);
        fr0 = frames;
        req_valid = 1; req_write = 0; req_addr = 24'h000001; req_len = 1;
        @(negedge clk);
        req_valid = 0;
        wait_idle();
        repeat (4) @(negedge clk);
        check("R9 no stray read", rcount - r0 == 0, rcount - r0, 0);
        check("R7 one done", wdone_cnt - d0 == 1, wdone_cnt - d0, 1);
        check("R7 done after clear", done_early == 0, done_early, 0);
        check("R4 wren frame", wren_frames - f_w == 1, wren_frames - f_w, 1);
        check("R4 enabled", no_wel_err - n0 == 0, no_wel_err - n0, 0);
        check("R5 prog frame", prog_frames - f_p == 1, prog_frames - f_p, 1);
        check("R6 polled repeatedly", stat_frames - f_s >= 2, stat_frames - f_s, 2);
        check("R9 frames after refusal", frames - fr0 == (stat_frames - f_s), frames - fr0, stat_frames - f_s);
        check("R8 cs high gap", min_hi >= CS_GAP, min_hi, CS_GAP);
        check("R5 stored byte", mem[a[7:0]] == exp, mem[a[7:0]], exp);
        test_read(a, 1);
        check("R5 readback", rbuf[rcount - 1] == exp, rbuf[rcount - 1], exp);
    endtask

    task automatic test_zero_len();
        int f0 = frames, r0 = rcount;
        issue(0, 24'h000010, 0, 8'h00);
        repeat (50) @(negedge clk);
        check("R10 no frame", frames - f0 == 0, frames - f0, 0);
        check("R10 no data", rcount - r0 == 0, rcount - r0, 0);
        check("R10 still ready", req_ready == 1, req_ready, 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        test_reset();
        test_read(24'h000010, 4);
        test_read(24'h0012FF, 1);
        test_read(24'h0000F8, 20);
        test_zero_len();
        test_prog(24'h000042, 8'h3C, 8'h3C);
        test_prog(24'h000042, 8'hF0, 8'h30);
        test_read(24'h000040, 6);
        check("R11 ready while selected", ready_viol == 0, ready_viol, 0);
        check("R11 strobe overlap", excl_viol == 0, excl_viol, 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule